// File: doc/BRIEF.md
# Per-select SPI clock and chip-select timer

This block generates the serial clock, the chip-select lines and the per-bit strobes for an SPI flash master. Up to five devices share the block. Each device has a 32-bit timing word, and a port-state word picks the active device and holds each device's clock polarity and phase. A data shifter starts a transaction by asserting `xfer_start` with a bit count. The block then runs four steps in order: it asserts the selected chip select, waits out the setup interval, produces the requested number of clock bits, and waits out the hold interval. After that it releases chip select and enforces a minimum gap before the next transaction can begin.

The bit rate comes from a 9-bit phase accumulator. In every clock bit cycle the accumulator adds the device's rate value B. Each crossing of a 256 boundary is one half-bit edge, and each wrap past 512 ends a bit. So B must be a power of two, and the bit rate is the input clock times B/512. The shifter receives `sample_en` and `shift_en`, each one cycle long. They line up with the leading or the trailing serial clock edge, depending on the device's phase bit.

Top module: `spi_clk_cs_timer`

## Requirements
- R1: While reset is held and just after it, every `cs_n` bit is 1, `sclk` is 0, `xfer_ready` is 1, and `xfer_done`, `sample_en` and `shift_en` are 0.
- R2: A write with `cfg_addr` = n, for n from 0 to 4, stores the timing word of device n. Its fields are rate B in bits 31:24, setup S in bits 23:16, hold H in bits 15:8 and gap D in bits 7:0. A write with `cfg_addr` = 5 stores the port state: select in bits 22:20, polarity of device n in bit 19−n, and phase of device n in bit 14−n.
- R3: Each serial clock bit lasts 512/B cycles, with the level changing every 256/B cycles. Rate codes 255 and 0 both act as 256, which gives a 2-cycle bit.
- R4: If chip select falls after clock edge E0, the first serial clock edge follows clock edge E(S+1+256/B).
- R5: Chip select rises H+1 cycles after the last serial clock edge, and `sclk` does not change in that cycle.
- R6: If `xfer_start` is held high, chip select stays high for D+2 cycles between two back-to-back transactions.
- R7: While idle, `sclk` rests at the polarity bit of the device named by the current select field. The level follows a port-state write within two cycles.
- R8: With phase 0, `sample_en` pulses with each leading edge (the edge away from the resting level) and `shift_en` pulses with each trailing edge. With phase 1 the two strobes swap. The two strobes never pulse in the same cycle.
- R9: At most one `cs_n` bit is low at a time, and it is the bit of the selected device. A select value of 5 to 7 asserts no chip select, but the clock and strobes still run.
- R10: A transaction produces exactly `xfer_bits` sample pulses. A bit count of 0 is treated as 1.
- R11: `xfer_start` is ignored while `xfer_ready` is 0. A timing-word write made during a transaction leaves that transaction's timing unchanged and applies from the next transaction.
- R12: `xfer_done` pulses for one cycle, in the cycle where chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Word index: 0..4 timing words, 5 port state |
| cfg_wdata | input | 32 | Configuration write data |
| xfer_start | input | 1 | Begin a transaction (taken only while ready) |
| xfer_bits | input | 16 | Number of bits in the transaction |
| xfer_ready | output | 1 | Idle and able to accept a start |
| xfer_done | output | 1 | One-cycle pulse when chip select releases |
| sample_en | output | 1 | Strobe: shifter samples input data |
| shift_en | output | 1 | Strobe: shifter drives next output bit |
| sclk | output | 1 | Serial clock |
| cs_n | output | 5 | Chip selects, active low |

## Verification
If an interval counter is loaded or decremented wrongly, the length of the chip-select low window changes. The wrong value therefore shows up in the first transaction that uses the affected device. A wrong accumulator step or a wrong edge classification shows up within one bit time, as a shifted first edge or as a strobe on the wrong clock edge. A wrong latched select or polarity shows up as the wrong `cs_n` bit going low, or as a wrong idle level two cycles after the port-state write.

// File: rtl/spi_clk_cs_timer.sv
module spi_clk_cs_timer #(
  parameter int N_CS  = 5,
  parameter int LEN_W = 16,
  localparam int ADDR_W = $clog2(N_CS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              xfer_start,
  input  logic [LEN_W-1:0]  xfer_bits,
  output logic              xfer_ready,
  output logic              xfer_done,
  output logic              sample_en,
  output logic              shift_en,
  output logic              sclk,
  output logic [N_CS-1:0]   cs_n
);
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RUN, S_HOLD, S_GAP} st_t;

  st_t             st;
  logic [31:0]     prm [N_CS];
  logic [2:0]      sel;
  logic [N_CS-1:0] pol, pha;

  logic            sel_ok, live_pol;
  logic [31:0]     word;
  logic [8:0]      eff;
  logic [N_CS-1:0] hot;

  logic            l_pha;
  logic [8:0]      l_rate;
  logic [7:0]      l_hold, l_gap, cnt;
  logic [LEN_W-1:0] rem;
  logic [8:0]      acc;
  logic [9:0]      sum;
  logic            toggle, wrap, lead;

  assign sel_ok   = sel < 3'(N_CS);
  assign live_pol = sel_ok ? pol[sel] : 1'b0;
  assign word     = sel_ok ? prm[sel] : '0;
  assign eff      = (word[31:24] == 8'd0 || word[31:24] == 8'hFF) ? 9'd256 : {1'b0, word[31:24]};
  assign hot      = sel_ok ? ({{(N_CS-1){1'b0}}, 1'b1} << sel) : '0;

  assign sum    = {1'b0, acc} + {1'b0, l_rate};
  assign toggle = sum[8] != acc[8];
  assign wrap   = sum[9];
  assign lead   = toggle && !wrap;

  assign xfer_ready = st == S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CS; i++) prm[i] <= '0;
      sel <= '0;
      pol <= '0;
      pha <= '0;
    end else if (cfg_we) begin
      if (int'(cfg_addr) < N_CS) prm[cfg_addr] <= cfg_wdata;
      else if (int'(cfg_addr) == N_CS) begin
        sel <= cfg_wdata[22:20];
        for (int i = 0; i < N_CS; i++) begin
          pol[i] <= cfg_wdata[19-i];
          pha[i] <= cfg_wdata[14-i];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cs_n      <= '1;
      sclk      <= 1'b0;
      sample_en <= 1'b0;
      shift_en  <= 1'b0;
      xfer_done <= 1'b0;
      l_pha     <= 1'b0;
      l_rate    <= '0;
      l_hold    <= '0;
      l_gap     <= '0;
      cnt       <= '0;
      rem       <= '0;
      acc       <= '0;
    end else begin
      sample_en <= 1'b0;
      shift_en  <= 1'b0;
      xfer_done <= 1'b0;
      case (st)
        S_IDLE: begin
          sclk <= live_pol;
          if (xfer_start) begin
            st     <= S_SETUP;
            cs_n   <= ~hot;
            l_pha  <= sel_ok ? pha[sel] : 1'b0;
            l_rate <= eff;
            cnt    <= word[23:16];
            l_hold <= word[15:8];
            l_gap  <= word[7:0];
            rem    <= xfer_bits;
            acc    <= '0;
          end
        end
        S_SETUP: begin
          if (cnt == 8'd0) st <= S_RUN;
          else cnt <= cnt - 8'd1;
        end
        S_RUN: begin
          acc       <= sum[8:0];
          if (toggle) sclk <= ~sclk;
          sample_en <= (lead && !l_pha) || (wrap && l_pha);
          shift_en  <= (lead && l_pha) || (wrap && !l_pha);
          if (wrap) begin
            if (rem <= LEN_W'(1)) begin
              st  <= S_HOLD;
              cnt <= l_hold;
            end else begin
              rem <= rem - LEN_W'(1);
            end
          end
        end
        S_HOLD: begin
          if (cnt == 8'd0) begin
            st        <= S_GAP;
            cs_n      <= '1;
            xfer_done <= 1'b1;
            cnt       <= l_gap;
          end else begin
            cnt <= cnt - 8'd1;
          end
        end
        S_GAP: begin
          if (cnt == 8'd0) st <= S_IDLE;
          else cnt <= cnt - 8'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_clk_cs_timer_chk.sv
module spi_clk_cs_timer_chk #(
  parameter int N_CS = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xfer_ready,
  input logic            xfer_done,
  input logic            sample_en,
  input logic            shift_en,
  input logic            sclk,
  input logic [N_CS-1:0] cs_n
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n)); // R9
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(sample_en && shift_en)); // R8
  AST_EDGE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_ready && $past(!xfer_ready) && sclk != $past(sclk)) |-> (sample_en || shift_en)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |=> !xfer_done); // R12
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |-> (&cs_n)); // R12
  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) xfer_done |-> $stable(sclk)); // R5
  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) xfer_ready |-> (&cs_n)); // R11
endmodule

bind spi_clk_cs_timer spi_clk_cs_timer_chk #(.N_CS(N_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_ready(xfer_ready), .xfer_done(xfer_done),
  .sample_en(sample_en), .shift_en(shift_en), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/spi_clk_cs_timer_tb.sv
module spi_clk_cs_timer_tb;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic        xfer_start = 0;
  logic [15:0] xfer_bits = 0;
  logic        xfer_ready, xfer_done, sample_en, shift_en, sclk;
  logic [4:0]  cs_n;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  spi_clk_cs_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .xfer_start(xfer_start), .xfer_bits(xfer_bits), .xfer_ready(xfer_ready),
    .xfer_done(xfer_done), .sample_en(sample_en), .shift_en(shift_en), .sclk(sclk), .cs_n(cs_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ps(input int s, input logic [4:0] cp, input logic [4:0] ph);
    logic [31:0] d = '0;
    d[22:20] = 3'(s);
    for (int i = 0; i < 5; i++) begin
      d[19-i] = cp[i];
      d[14-i] = ph[i];
    end
    return d;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic xfer(input int nb, input bit mid, output int low, output int first,
                      output int l2r, output int smp, output int lead, output int csv);
    int t = 0, last_e = -1, prev, cp;
    @(negedge clk);
    xfer_start = 1; xfer_bits = 16'(nb);
    @(negedge clk);
    xfer_start = 0;
    low = 0; first = -1; l2r = -1; smp = 0; lead = 0;
    prev = sclk; cp = sclk; csv = cs_n;
    while (t < 5000) begin
      if (cs_n != 5'h1F) low++;
      if (sclk != prev) begin
        if (first < 0) first = t;
        last_e = t; prev = sclk;
      end
      if (sample_en) begin
        smp++;
        if (sclk != cp) lead++;
      end
      if (xfer_done) begin
        l2r = t - last_e;
        break;
      end
      if (mid && t == 3) begin
        cfg_we = 1; cfg_addr = 0; cfg_wdata = 32'hFF090909; xfer_start = 1;
      end else begin
        cfg_we = 0; xfer_start = 0;
      end
      @(negedge clk);
      t++;
    end
    cfg_we = 0; xfer_start = 0;
    while (!xfer_ready) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 cs_n", cs_n, 5'h1F);
    chk("R1 sclk", sclk, 0);
    chk("R1 ready", xfer_ready, 1);
    chk("R1 strobes", {xfer_done, sample_en, shift_en}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {cs_n, sclk, xfer_ready}, {5'h1F, 1'b0, 1'b1});
  endtask

  task automatic t_fast_cpha0;
    int low, first, l2r, smp, lead, csv;
    wr(0, 32'hFF020304);
    wr(5, ps(0, 5'b00000, 5'b00000));
    xfer(4, 0, low, first, l2r, smp, lead, csv);
    chk("R3 R5 cs low window", low, 15);
    chk("R4 first edge", first, 4);
    chk("R5 hold after last edge", l2r, 4);
    chk("R10 sample count", smp, 4);
    chk("R8 cpha0 samples on leading", lead, 4);
    chk("R9 device0 selected", csv, 5'b11110);
  endtask

  task automatic t_slow_cpha1;
    int low, first, l2r, smp, lead, csv;
    wr(1, 32'h40000001);
    wr(5, ps(1, 5'b00010, 5'b00010));
    chk("R7 idle level follows polarity", sclk, 1);
    xfer(2, 0, low, first, l2r, smp, lead, csv);
    chk("R3 slow rate window", low, 18);
    chk("R4 first edge slow", first, 5);
    chk("R5 zero hold", l2r, 1);
    chk("R10 sample count slow", smp, 2);
    chk("R8 cpha1 samples on trailing", lead, 0);
    chk("R9 device1 selected", csv, 5'b11101);
  endtask

  task automatic t_zero_codes;
    int low, first, l2r, smp, lead, csv;
    wr(2, 32'h00010101);
    wr(5, ps(2, 5'b00000, 5'b00000));
    xfer(0, 0, low, first, l2r, smp, lead, csv);
    chk("R3 rate 0 as 256", low, 6);
    chk("R10 zero bits as one", smp, 1);
    chk("R4 first edge s=1", first, 3);
  endtask

  task automatic t_gap;
    int high = 0;
    wr(5, ps(0, 5'b00000, 5'b00000));
    @(negedge clk);
    xfer_bits = 1; xfer_start = 1;
    while (cs_n == 5'h1F) @(negedge clk);
    while (!xfer_done) @(negedge clk);
    while (cs_n == 5'h1F && high < 1000) begin
      high++;
      @(negedge clk);
    end
    xfer_start = 0;
    chk("R6 gap between transactions", high, 6);
    while (!xfer_ready) @(negedge clk);
  endtask

  task automatic t_midwrite;
    int low, first, l2r, smp, lead, csv;
    xfer(4, 1, low, first, l2r, smp, lead, csv);
    chk("R11 running timing unchanged", low, 15);
    chk("R11 second start ignored", smp, 4);
    @(negedge clk);
    chk("R11 no restart after done", cs_n, 5'h1F);
    xfer(1, 0, low, first, l2r, smp, lead, csv);
    chk("R2 R11 new word applies next", low, 22);
    wr(0, 32'hFF020304);
  endtask

  task automatic t_bad_select;
    int low, first, l2r, smp, lead, csv;
    wr(5, ps(6, 5'b00000, 5'b00000));
    xfer(3, 0, low, first, l2r, smp, lead, csv);
    chk("R9 no select asserted", low, 0);
    chk("R9 strobes still run", smp, 3);
  endtask

  task automatic t_polarity_bits;
    wr(5, ps(4, 5'b10000, 5'b00000));
    chk("R2 R7 device4 polarity bit15", sclk, 1);
    wr(5, ps(4, 5'b01111, 5'b00000));
    chk("R7 other polarity bits ignored", sclk, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_fast_cpha0();
    t_slow_cpha1();
    t_zero_codes();
    t_gap();
    t_midwrite();
    t_bad_select();
    t_polarity_bits();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule